// File: doc/BRIEF.md
# Flash Block Lock Protection Manager

This block keeps the write-protection state of a NOR flash array divided into equal erase blocks. It holds one protection bit per block and one master protection bit, and it decides for every decoded request (erase a block, program a block, lock one block, set the master protection, release all block protection) whether the request may go ahead. The protection bits live in registers that stand in for nonvolatile cells. They are loaded from parameters only at power-on reset.

A command decoder in front of the block presents one request at a time with an operation code and a block index. One cycle later the block answers with a single-cycle grant or deny pulse. A granted request holds a busy flag for a fixed number of cycles to model the operation time. Requests that arrive while busy are dropped. Two inputs override the protection bits. A program-enable input that is low refuses everything. A device-reset or power-down input that is high also refuses everything. Every refusal sets a sticky error flag that status logic reads and clears with a one-cycle pulse.

Top module: `flash_lock_guard`

## Requirements
- R1: After power-on reset (rstN low), busy, grant, deny and errFlag are 0. lockBits equals the INIT_LOCKS parameter and masterLock equals INIT_MASTER (both zero by default).
- R2: An erase (reqOp 1) or program (reqOp 2) request is granted when the bit of the addressed block in lockBits is 0 and denied when it is 1. Neither operation changes any protection bit.
- R3: A set-block-lock request (reqOp 3) with masterLock clear is granted and sets only lockBits[reqBlock].
- R4: A clear-block-locks request (reqOp 5) with masterLock clear is granted and clears every bit of lockBits in one step.
- R5: A set-master request (reqOp 4) is granted whenever the overrides allow it and sets masterLock, which only power-on reset clears. While masterLock is 1, set-block-lock and clear-block-locks are denied and lockBits stays unchanged. Erase and program still follow the per-block bits.
- R6: While progEnable is 0, every request with reqOp 1 to 5 is denied and no protection bit changes.
- R7: While holdReset is 1, every request with reqOp 1 to 5 is denied and no protection bit changes.
- R8: A request with reqOp 1 to 5 that is sampled while idle gives exactly one of grant or deny, as a one-cycle pulse in the cycle after the sampling edge. Codes 0, 6 and 7 give neither pulse and change no state.
- R9: busy rises together with grant and stays high for exactly BUSY_CYCLES cycles. A request sampled while busy is high gives no pulse and changes no state.
- R10: A deny sets errFlag. errFlag stays set until a clock edge samples clrStatus high. If a deny comes from the same edge that samples clrStatus, errFlag remains set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Power-on reset, active low, asynchronous; loads initial protection state |
| holdReset | input | 1 | Device held in reset or power-down; refuses all requests |
| progEnable | input | 1 | Program-enable voltage good; low refuses all requests |
| reqValid | input | 1 | Request present this cycle |
| reqOp | input | 3 | Operation: 1 erase, 2 program, 3 lock block, 4 set master, 5 clear block locks |
| reqBlock | input | $clog2(NUM_BLOCKS) | Addressed erase block |
| clrStatus | input | 1 | Clears the error flag |
| grant | output | 1 | One-cycle pulse: request accepted |
| deny | output | 1 | One-cycle pulse: request refused |
| busy | output | 1 | Granted operation in progress |
| errFlag | output | 1 | Sticky refusal flag |
| masterLock | output | 1 | Master protection bit |
| lockBits | output | NUM_BLOCKS | Per-block protection bits |

## Verification
The error flag has two sources that can meet on one edge: a refused request sets it and a clrStatus pulse clears it. The bench drives a request to a protected block in the same cycle as clrStatus. On the next cycle it expects both the deny pulse and a flag that is still set. A following clrStatus pulse with no request must then bring the flag to zero. A second overlap is a new request that arrives while busy from a just-granted lock operation. For that case the bench checks for no pulse and for a lockBits vector that lacks the second block's bit.

// File: rtl/lock_guard_pkg.sv
package lock_guard_pkg;

  localparam logic [2:0] OP_ERASE      = 3'd1;
  localparam logic [2:0] OP_PROG       = 3'd2;
  localparam logic [2:0] OP_SET_BLK    = 3'd3;
  localparam logic [2:0] OP_SET_MASTER = 3'd4;
  localparam logic [2:0] OP_CLR_BLKS   = 3'd5;

  // strobes from control to the protection store, valid for one edge
  typedef struct packed {
    logic setBlk;
    logic setMaster;
    logic clrBlks;
    logic raiseErr;
  } lockStrobe_t;

endpackage

// File: rtl/lock_guard_ctrl.sv
module lock_guard_ctrl
  import lock_guard_pkg::*;
#(
  parameter int BUSY_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [2:0]  reqOp,
  input  logic        holdReset,
  input  logic        progEnable,
  input  logic        blkIsLocked,
  input  logic        masterIsSet,
  output lockStrobe_t strobe,
  output logic        grant,
  output logic        deny,
  output logic        busy
);

  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYCLES);

  logic [CNT_W-1:0] busyCnt;
  logic opKnown;
  logic allowed;
  logic take;
  logic grantNext;
  logic denyNext;

  always_comb begin
    opKnown = 1'b0;
    allowed = 1'b0;
    unique case (reqOp)
      OP_ERASE, OP_PROG: begin
        opKnown = 1'b1;
        allowed = !blkIsLocked;
      end
      OP_SET_BLK, OP_CLR_BLKS: begin
        opKnown = 1'b1;
        allowed = !masterIsSet;
      end
      OP_SET_MASTER: begin
        opKnown = 1'b1;
        allowed = 1'b1;
      end
      default: begin
        opKnown = 1'b0;
        allowed = 1'b0;
      end
    endcase
    // the enable pin and the reset hold override every lock bit
    allowed   = allowed && progEnable && !holdReset;
    take      = reqValid && !busy && opKnown;
    grantNext = take && allowed;
    denyNext  = take && !allowed;

    strobe.setBlk    = grantNext && (reqOp == OP_SET_BLK);
    strobe.setMaster = grantNext && (reqOp == OP_SET_MASTER);
    strobe.clrBlks   = grantNext && (reqOp == OP_CLR_BLKS);
    strobe.raiseErr  = denyNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grant   <= 1'b0;
      deny    <= 1'b0;
      busyCnt <= '0;
    end else begin
      grant <= grantNext;
      deny  <= denyNext;
      if (holdReset)
        busyCnt <= '0;
      else if (grantNext)
        busyCnt <= CNT_LOAD;
      else if (busyCnt != '0)
        busyCnt <= busyCnt - 1'b1;
    end
  end

  assign busy = (busyCnt != '0);

endmodule

// File: rtl/lock_guard_store.sv
module lock_guard_store
  import lock_guard_pkg::*;
#(
  parameter int NUM_BLOCKS = 64,
  parameter logic [NUM_BLOCKS-1:0] INIT_LOCKS = '0,
  parameter logic INIT_MASTER = 1'b0,
  localparam int BLK_W = $clog2(NUM_BLOCKS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  lockStrobe_t           strobe,
  input  logic [BLK_W-1:0]      reqBlock,
  input  logic                  clrStatus,
  output logic [NUM_BLOCKS-1:0] lockBits,
  output logic                  masterLock,
  output logic                  errFlag,
  output logic                  blkIsLocked
);

  logic [NUM_BLOCKS-1:0] lockNext;

  for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_bit
    assign lockNext[g] = strobe.clrBlks ? 1'b0 :
                         (strobe.setBlk && (reqBlock == BLK_W'(g))) ? 1'b1 :
                         lockBits[g];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockBits   <= INIT_LOCKS;
      masterLock <= INIT_MASTER;
      errFlag    <= 1'b0;
    end else begin
      lockBits <= lockNext;
      if (strobe.setMaster)
        masterLock <= 1'b1;
      // a new refusal wins over a clear in the same cycle
      errFlag <= strobe.raiseErr || (errFlag && !clrStatus);
    end
  end

  assign blkIsLocked = lockBits[reqBlock];

endmodule

// File: rtl/flash_lock_guard.sv
module flash_lock_guard
  import lock_guard_pkg::*;
#(
  parameter int NUM_BLOCKS = 64,
  parameter int BUSY_CYCLES = 4,
  parameter logic [NUM_BLOCKS-1:0] INIT_LOCKS = '0,
  parameter logic INIT_MASTER = 1'b0,
  localparam int BLK_W = $clog2(NUM_BLOCKS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  holdReset,
  input  logic                  progEnable,
  input  logic                  reqValid,
  input  logic [2:0]            reqOp,
  input  logic [BLK_W-1:0]      reqBlock,
  input  logic                  clrStatus,
  output logic                  grant,
  output logic                  deny,
  output logic                  busy,
  output logic                  errFlag,
  output logic                  masterLock,
  output logic [NUM_BLOCKS-1:0] lockBits
);

  lockStrobe_t strobe;
  logic blkIsLocked;

  lock_guard_ctrl #(
    .BUSY_CYCLES(BUSY_CYCLES)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqOp      (reqOp),
    .holdReset  (holdReset),
    .progEnable (progEnable),
    .blkIsLocked(blkIsLocked),
    .masterIsSet(masterLock),
    .strobe     (strobe),
    .grant      (grant),
    .deny       (deny),
    .busy       (busy)
  );

  lock_guard_store #(
    .NUM_BLOCKS (NUM_BLOCKS),
    .INIT_LOCKS (INIT_LOCKS),
    .INIT_MASTER(INIT_MASTER)
  ) u_store (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqBlock   (reqBlock),
    .clrStatus  (clrStatus),
    .lockBits   (lockBits),
    .masterLock (masterLock),
    .errFlag    (errFlag),
    .blkIsLocked(blkIsLocked)
  );

endmodule

// File: rtl/flash_lock_guard_chk.sv
module flash_lock_guard_chk #(
  parameter int NUM_BLOCKS = 64
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  holdReset,
  input logic                  progEnable,
  input logic                  clrStatus,
  input logic                  grant,
  input logic                  deny,
  input logic                  busy,
  input logic                  errFlag,
  input logic                  masterLock,
  input logic [NUM_BLOCKS-1:0] lockBits
);

  a_r8_one_answer: assert property (@(posedge clk) disable iff (!rstN)
    !(grant && deny));

  a_r9_grant_busy: assert property (@(posedge clk) disable iff (!rstN)
    grant |-> busy);

  a_r9_busy_quiet: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (!grant && !deny));

  a_r10_deny_flags: assert property (@(posedge clk) disable iff (!rstN)
    deny |-> errFlag);

  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !clrStatus) |=> errFlag);

  a_r5_master_holds: assert property (@(posedge clk) disable iff (!rstN)
    masterLock |=> masterLock);

  a_r5_bits_frozen: assert property (@(posedge clk) disable iff (!rstN)
    masterLock |=> $stable(lockBits));

  a_r6_grant_enabled: assert property (@(posedge clk) disable iff (!rstN)
    grant |-> ($past(progEnable) && !$past(holdReset)));

endmodule

bind flash_lock_guard flash_lock_guard_chk #(.NUM_BLOCKS(NUM_BLOCKS)) u_chk (.*);

// File: tb/sim_flash_lock_guard.sv
`timescale 1ns/1ps
module sim_flash_lock_guard;
  localparam int NB = 8;
  localparam int BW = 3;
  localparam int BC = 3;

  logic clk = 1'b0;
  logic rstN, holdReset, progEnable, reqValid, clrStatus;
  logic [2:0] reqOp;
  logic [BW-1:0] reqBlock;
  logic grant, deny, busy, errFlag, masterLock;
  logic [NB-1:0] lockBits;
  logic g1, d1, b1, e1, m1;
  logic [NB-1:0] l1;

  int checks = 0;
  int errors = 0;
  logic [NB-1:0] mLocks = '0;
  logic mMaster = 1'b0;
  logic mErr = 1'b0;

  always #10 clk = ~clk;

  flash_lock_guard #(.NUM_BLOCKS(NB), .BUSY_CYCLES(BC)) u0 (
    .clk(clk), .rstN(rstN), .holdReset(holdReset), .progEnable(progEnable),
    .reqValid(reqValid), .reqOp(reqOp), .reqBlock(reqBlock), .clrStatus(clrStatus),
    .grant(grant), .deny(deny), .busy(busy), .errFlag(errFlag),
    .masterLock(masterLock), .lockBits(lockBits));

  // second instance with non-default power-on state, inputs idle
  flash_lock_guard #(.NUM_BLOCKS(NB), .BUSY_CYCLES(BC),
                     .INIT_LOCKS(8'h81), .INIT_MASTER(1'b1)) u1 (
    .clk(clk), .rstN(rstN), .holdReset(1'b0), .progEnable(1'b1),
    .reqValid(1'b0), .reqOp(3'd0), .reqBlock('0), .clrStatus(1'b0),
    .grant(g1), .deny(d1), .busy(b1), .errFlag(e1),
    .masterLock(m1), .lockBits(l1));

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(string tag, logic [2:0] op, int blk);
    logic known, ok, eg, ed;
    int n;
    @(negedge clk);
    reqValid = 1'b1; reqOp = op; reqBlock = BW'(blk);
    known = (op >= 3'd1) && (op <= 3'd5);
    ok = !holdReset && progEnable;
    if (op == 3'd1 || op == 3'd2) ok = ok && !mLocks[blk];
    if (op == 3'd3 || op == 3'd5) ok = ok && !mMaster;
    eg = known && ok;
    ed = known && !ok;
    @(negedge clk);
    reqValid = 1'b0;
    if (eg) begin
      if (op == 3'd3) mLocks[blk] = 1'b1;
      if (op == 3'd4) mMaster = 1'b1;
      if (op == 3'd5) mLocks = '0;
    end
    if (ed) mErr = 1'b1;
    chk({tag, " grant"}, 64'(grant), 64'(eg));
    chk({tag, " deny"}, 64'(deny), 64'(ed));
    chk({tag, " errFlag"}, 64'(errFlag), 64'(mErr));
    chk({tag, " lockBits"}, 64'(lockBits), 64'(mLocks));
    chk({tag, " masterLock"}, 64'(masterLock), 64'(mMaster));
    if (eg) begin
      n = 0;
      while (busy) begin
        n++;
        @(negedge clk);
      end
      chk("R9 busy length", 64'(n), 64'(BC));
    end
  endtask

  task automatic pulseClr();
    @(negedge clk); clrStatus = 1'b1;
    @(negedge clk); clrStatus = 1'b0;
    mErr = 1'b0;
    chk("R10 cleared", 64'(errFlag), 64'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; holdReset = 1'b0; progEnable = 1'b1; reqValid = 1'b0;
    clrStatus = 1'b0; reqOp = '0; reqBlock = '0;
    repeat (3) @(negedge clk);
    // R1 reset state, default and parameterized
    chk("R1 busy", 64'(busy), 0);
    chk("R1 grant", 64'(grant), 0);
    chk("R1 deny", 64'(deny), 0);
    chk("R1 errFlag", 64'(errFlag), 0);
    chk("R1 lockBits", 64'(lockBits), 0);
    chk("R1 masterLock", 64'(masterLock), 0);
    chk("R1 init locks", 64'(l1), 64'h81);
    chk("R1 init master", 64'(m1), 1);
    rstN = 1'b1;

    // R2 all blocks open
    for (int b = 0; b < NB; b++) begin
      issue("R2 erase open", 3'd1, b);
      issue("R2 prog open", 3'd2, b);
    end
    // R3 lock odd blocks
    for (int b = 1; b < NB; b += 2) issue("R3 set lock", 3'd3, b);
    chk("R3 odd pattern", 64'(lockBits), 64'hAA);
    // R2 locked blocks refused
    for (int b = 0; b < NB; b++) begin
      issue("R2 erase", 3'd1, b);
      issue("R2 prog", 3'd2, b);
    end
    repeat (5) @(negedge clk);
    chk("R10 sticky", 64'(errFlag), 1);
    pulseClr();

    // R8 unknown codes ignored
    issue("R8 code0", 3'd0, 1);
    issue("R8 code6", 3'd6, 2);
    issue("R8 code7", 3'd7, 4);

    // R6 enable pin low
    progEnable = 1'b0;
    for (int op = 1; op <= 5; op++)
      for (int b = 0; b < 2; b++) issue("R6 no enable", 3'(op), b);
    progEnable = 1'b1;
    pulseClr();

    // R7 reset hold
    holdReset = 1'b1;
    for (int op = 1; op <= 5; op++)
      for (int b = 2; b < 4; b++) issue("R7 hold", 3'(op), b);
    holdReset = 1'b0;
    pulseClr();

    // R10 deny and clear on the same edge
    @(negedge clk);
    reqValid = 1'b1; reqOp = 3'd1; reqBlock = 3'd1; clrStatus = 1'b1;
    @(negedge clk);
    reqValid = 1'b0; clrStatus = 1'b0; mErr = 1'b1;
    chk("R10 same-cycle deny", 64'(deny), 1);
    chk("R10 same-cycle flag", 64'(errFlag), 1);
    pulseClr();

    // R9 request while busy dropped
    @(negedge clk);
    reqValid = 1'b1; reqOp = 3'd3; reqBlock = 3'd2;
    @(negedge clk);
    reqBlock = 3'd4;
    mLocks[2] = 1'b1;
    chk("R9 first grant", 64'(grant), 1);
    @(negedge clk);
    reqValid = 1'b0;
    chk("R9 busy grant", 64'(grant), 0);
    chk("R9 busy deny", 64'(deny), 0);
    chk("R9 busy locks", 64'(lockBits), 64'(mLocks));
    while (busy) @(negedge clk);

    // R4 clear all together
    issue("R4 clear all", 3'd5, 0);
    chk("R4 all clear", 64'(lockBits), 0);
    issue("R3 set 5", 3'd3, 5);
    issue("R3 set 6", 3'd3, 6);

    // R5 master protection
    issue("R5 set master", 3'd4, 0);
    issue("R5 master again", 3'd4, 3);
    issue("R5 lock refused", 3'd3, 0);
    issue("R5 clear refused", 3'd5, 0);
    issue("R5 erase locked", 3'd1, 5);
    issue("R5 erase open", 3'd1, 0);
    chk("R5 frozen bits", 64'(lockBits), 64'h60);
    pulseClr();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule